// File: doc/BRIEF.md
# Puncturing pattern generator

This block builds a keep/drop mask for one turbo-coded block ahead of rate matching. A start pulse captures the block length and two sets of error-accumulation parameters, one set per parity stream. The block then makes one decision per clock for each coded bit position and writes the result into an internal one-bit-wide pattern memory at the position's address. A stored 1 means the bit at that position is removed, and a stored 0 means it is kept.

The coded bits arrive in a fixed cyclic order: systematic, parity 1, parity 2. Systematic positions are always kept. Each parity stream runs the error rule with its own running error value. The error value is first reduced by the stream's decrement. When the result is zero or below, the bit is dropped and the stream's increment is added back. Otherwise the bit is kept and the reduced value is carried forward. Once the walk is finished, the downstream data path reads the mask through a synchronous read port.

Top module: `punc_mask_gen`

## Requirements
- R1: While reset is held and after it is released, with no start pulse, `busy` and `done` are both 0.
- R2: A start pulse accepted in idle makes `busy` high for exactly N+1 clock cycles, where N is `blk_len`. `done` is then high for exactly one cycle, in the first cycle after `busy` falls.
- R3: Every position p in 0..N-1 with p mod 3 = 0 (systematic) is stored as 0 (keep).
- R4: Positions with p mod 3 = 1 use the parity-1 parameters and positions with p mod 3 = 2 use the parity-2 parameters. Each stream's error starts at its eini. For each of the stream's positions in order, e is reduced by eminus. The stored bit is 1 when the result is 0 or below, and the new error is then the result plus eplus. Otherwise the stored bit is 0 and the new error is the result.
- R5: A parity stream with eminus = 0 and eini > 0 has no position stored as 1.
- R6: A start pulse while `busy` is high is ignored: the walk in progress, its parameters and its timing are unchanged.
- R7: `rd_bit` shows the stored bit at the `rd_addr` sampled at the previous rising clock edge. It does not change before that edge.
- R8: Positions N and above keep the contents they held before the walk. With N = 0 nothing is written, and `busy` lasts one cycle.
- R9: With eplus >= eminus for both streams and any 16-bit parameter values, including all at their maximum, the error values never wrap. The stored mask follows R4 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that begins a walk when idle |
| blk_len | input | CNT_W (11) | Number of coded bit positions N, at most DEPTH |
| p1_eini | input | ERR_W (16) | Parity-1 initial error |
| p1_eplus | input | ERR_W (16) | Parity-1 increment after a drop |
| p1_eminus | input | ERR_W (16) | Parity-1 decrement per position |
| p2_eini | input | ERR_W (16) | Parity-2 initial error |
| p2_eplus | input | ERR_W (16) | Parity-2 increment after a drop |
| p2_eminus | input | ERR_W (16) | Parity-2 decrement per position |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when the walk ends |
| rd_addr | input | ADDR_W (10) | Mask read address |
| rd_bit | output | 1 | Mask bit at the address sampled last edge (1 = drop) |

## Verification
On every cycle, the checker confirms the following: `done` is a single-cycle pulse that closes each busy period, write addresses start at 0 and step by one, the stream tag rotates in the fixed order, systematic writes carry a keep, a start during a walk cannot restart it, and both error registers stay inside their unsigned parameter range. Only the bench's scenarios can show the actual mask values, because checking them needs a model of the error loop per stream. The same applies to the busy length for a given N, the untouched contents beyond N, the effect of eminus = 0, and the read-port latency.

// File: rtl/punc_pkg.sv
package punc_pkg;

  typedef enum logic [1:0] {
    STRM_SYS  = 2'd0,
    STRM_PAR1 = 2'd1,
    STRM_PAR2 = 2'd2
  } strm_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;

  // Fixed cyclic order of coded bits: systematic, parity 1, parity 2.
  function automatic strm_e strm_next(strm_e s);
    case (s)
      STRM_SYS:  strm_next = STRM_PAR1;
      STRM_PAR1: strm_next = STRM_PAR2;
      default:   strm_next = STRM_SYS;
    endcase
  endfunction

endpackage

// File: rtl/punc_err_step.sv
// Combinational decision path: subtract, compare with zero, conditional add.
module punc_err_step #(
  parameter int EW = 18
) (
  input  logic [EW-1:0] e_in,
  input  logic [EW-1:0] e_dec,
  input  logic [EW-1:0] e_inc,
  output logic [EW-1:0] e_out,
  output logic          drop
);

  logic [EW-1:0] diff;

  always_comb begin
    diff  = e_in - e_dec;
    drop  = diff[EW-1] || (diff == '0);
    e_out = drop ? (diff + e_inc) : diff;
  end

endmodule

// File: rtl/punc_err_bank.sv
// One error register and parameter set per parity stream.
module punc_err_bank
  import punc_pkg::*;
#(
  parameter int ERR_W = 16,
  localparam int EW = ERR_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  step,
  input  strm_e                 strm,
  input  logic [1:0][ERR_W-1:0] eini,
  input  logic [1:0][ERR_W-1:0] eplus,
  input  logic [1:0][ERR_W-1:0] eminus,
  output logic                  drop,
  output logic [1:0][EW-1:0]    err
);

  logic [1:0] drop_v;

  for (genvar g = 0; g < 2; g++) begin : g_strm
    localparam strm_e MY_STRM = (g == 0) ? STRM_PAR1 : STRM_PAR2;

    logic [EW-1:0] e_q, e_d, e_nx;
    logic [EW-1:0] inc_q, dec_q;
    logic          sel, dr;

    assign sel = (strm == MY_STRM);

    punc_err_step #(.EW(EW)) u_step (
      .e_in  (e_q),
      .e_dec (dec_q),
      .e_inc (inc_q),
      .e_out (e_nx),
      .drop  (dr)
    );

    always_comb begin
      e_d = e_q;
      if (load) begin
        e_d = EW'(eini[g]);
      end else if (step && sel) begin
        e_d = e_nx;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_q <= '0;
      end else begin
        e_q <= e_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inc_q <= '0;
        dec_q <= '0;
      end else if (load) begin
        inc_q <= EW'(eplus[g]);
        dec_q <= EW'(eminus[g]);
      end
    end

    assign drop_v[g] = sel && dr;
    assign err[g]    = e_q;
  end

  assign drop = |drop_v;

endmodule

// File: rtl/punc_ctrl.sv
// Walk sequencer: position counter, stream phase, write gating, done pulse.
module punc_ctrl
  import punc_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  n_len,
  output logic              busy,
  output logic              done,
  output logic              load,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output strm_e             strm
);

  st_e              st_q, st_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0] n_q, n_d;
  strm_e            strm_q, strm_d;
  logic             done_q, done_d;

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    n_d    = n_q;
    strm_d = strm_q;
    done_d = 1'b0;
    load   = 1'b0;
    wr_en  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_RUN;
          pos_d  = '0;
          n_d    = n_len;
          strm_d = STRM_SYS;
          load   = 1'b1;
        end
      end
      default: begin
        if (pos_q == n_q) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          wr_en  = 1'b1;
          pos_d  = pos_q + 1'b1;
          strm_d = strm_next(strm_q);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pos_q  <= '0;
      n_q    <= '0;
      strm_q <= STRM_SYS;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      n_q    <= n_d;
      strm_q <= strm_d;
      done_q <= done_d;
    end
  end

  assign busy    = (st_q == ST_RUN);
  assign done    = done_q;
  assign wr_addr = pos_q[ADDR_W-1:0];
  assign strm    = strm_q;

endmodule

// File: rtl/punc_mask_ram.sv
// One-bit-wide pattern memory, one write port, one registered read port.
module punc_mask_ram #(
  parameter int DEPTH = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wbit,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rbit
);

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wbit;
    end
    rbit <= mem[raddr];
  end

endmodule

// File: rtl/punc_mask_gen.sv
module punc_mask_gen
  import punc_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int ERR_W = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int EW = ERR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  blk_len,
  input  logic [ERR_W-1:0]  p1_eini,
  input  logic [ERR_W-1:0]  p1_eplus,
  input  logic [ERR_W-1:0]  p1_eminus,
  input  logic [ERR_W-1:0]  p2_eini,
  input  logic [ERR_W-1:0]  p2_eplus,
  input  logic [ERR_W-1:0]  p2_eminus,
  output logic              busy,
  output logic              done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  logic              load, wr_en, wr_bit;
  logic [ADDR_W-1:0] wr_addr;
  strm_e             strm;
  logic [1:0][EW-1:0] err;

  punc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .start   (start),
    .n_len   (blk_len),
    .busy    (busy),
    .done    (done),
    .load    (load),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .strm    (strm)
  );

  punc_err_bank #(.ERR_W(ERR_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load   (load),
    .step   (wr_en),
    .strm   (strm),
    .eini   ({p2_eini, p1_eini}),
    .eplus  ({p2_eplus, p1_eplus}),
    .eminus ({p2_eminus, p1_eminus}),
    .drop   (wr_bit),
    .err    (err)
  );

  punc_mask_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wbit  (wr_bit),
    .raddr (rd_addr),
    .rbit  (rd_bit)
  );

endmodule

// File: rtl/punc_mask_gen_chk.sv
module punc_mask_gen_chk
  import punc_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int ERR_W = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int EW = ERR_W + 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic               wr_bit,
  input logic [1:0]         strm,
  input logic [1:0][EW-1:0] err
);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !$past(wr_en)) |-> (wr_addr == '0));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

  p_sys_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && strm == 2'd0) |-> !wr_bit);

  p_strm_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (strm == strm_next(strm_e'($past(strm)))));

  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err[0][EW-1:ERR_W] == '0) && (err[1][EW-1:ERR_W] == '0));

endmodule

bind punc_mask_gen punc_mask_gen_chk #(.DEPTH(DEPTH), .ERR_W(ERR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_bit  (wr_bit),
  .strm    (strm),
  .err     (err)
);

// File: tb/punc_mask_gen_test.sv
`timescale 1ns/1ps
module punc_mask_gen_test;

  localparam int DEPTH = 1024;
  localparam int ERR_W = 16;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int EMAX = (1 << ERR_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [CNT_W-1:0]  blk_len;
  logic [ERR_W-1:0]  p1_eini, p1_eplus, p1_eminus;
  logic [ERR_W-1:0]  p2_eini, p2_eplus, p2_eminus;
  logic              busy, done, rd_bit;
  logic [ADDR_W-1:0] rd_addr;

  always #10 clk = ~clk;

  punc_mask_gen #(.DEPTH(DEPTH), .ERR_W(ERR_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
    .p1_eini(p1_eini), .p1_eplus(p1_eplus), .p1_eminus(p1_eminus),
    .p2_eini(p2_eini), .p2_eplus(p2_eplus), .p2_eminus(p2_eminus),
    .busy(busy), .done(done), .rd_addr(rd_addr), .rd_bit(rd_bit)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit exp_mask [DEPTH];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Behavioural model of the error loop; positions >= n keep old contents.
  function automatic void model(int n, int i1, int a1, int m1, int i2, int a2, int m2);
    longint e1 = i1;
    longint e2 = i2;
    for (int p = 0; p < n; p++) begin
      if (p % 3 == 0) begin
        exp_mask[p] = 1'b0;
      end else if (p % 3 == 1) begin
        e1 = e1 - m1;
        exp_mask[p] = (e1 <= 0);
        if (e1 <= 0) e1 = e1 + a1;
      end else begin
        e2 = e2 - m2;
        exp_mask[p] = (e2 <= 0);
        if (e2 <= 0) e2 = e2 + a2;
      end
    end
  endfunction

  task automatic read_bit(input int a, output bit b);
    rd_addr = ADDR_W'(a);
    @(posedge clk);
    @(negedge clk);
    b = rd_bit;
  endtask

  task automatic run(input int n, input int i1, input int a1, input int m1,
                     input int i2, input int a2, input int m2,
                     input bit poke, input string ptag);
    int cnt = 0;
    int sys_bad = 0, par_bad = 0, old_bad = 0, p1_ones = 0;
    bit b;
    model(n, i1, a1, m1, i2, a2, m2);
    @(negedge clk);
    blk_len = CNT_W'(n);
    p1_eini = ERR_W'(i1); p1_eplus = ERR_W'(a1); p1_eminus = ERR_W'(m1);
    p2_eini = ERR_W'(i2); p2_eplus = ERR_W'(a2); p2_eminus = ERR_W'(m2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cnt < 5000) begin
      if (busy) cnt++;
      if (poke && cnt == 2) begin
        start = 1'b1; blk_len = CNT_W'(3); p1_eminus = '0; p1_eini = '1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(cnt == n + 1, poke ? "R6" : "R2", "busy cycles", cnt, n + 1);
    @(negedge clk);
    check(!done && !busy, "R2", "done single pulse", int'(done), 0);
    for (int p = 0; p < DEPTH; p++) begin
      read_bit(p, b);
      if (b != exp_mask[p]) begin
        if (p >= n) old_bad++;
        else if (p % 3 == 0) sys_bad++;
        else par_bad++;
      end
      if (p < n && p % 3 == 1 && b) p1_ones++;
    end
    check(sys_bad == 0, "R3", "systematic mismatches", sys_bad, 0);
    check(par_bad == 0, ptag, "parity mismatches", par_bad, 0);
    check(old_bad == 0, "R8", "mismatches beyond N", old_bad, 0);
    if (m1 == 0 && i1 > 0)
      check(p1_ones == 0, "R5", "parity-1 drops with eminus 0", p1_ones, 0);
  endtask

  task automatic rand_run(input bit poke);
    int a1 = $urandom_range(EMAX, 1);
    int a2 = $urandom_range(EMAX, 1);
    int m1 = $urandom_range(a1, 0);
    int m2 = $urandom_range(a2, 0);
    int i1 = $urandom_range(a1, 1);
    int i2 = $urandom_range(a2, 1);
    int n  = $urandom_range(DEPTH, 4);
    run(n, i1, a1, m1, i2, a2, m2, poke, "R4");
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit b0, b1;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; start = 1'b0; blk_len = '0; rd_addr = '0;
    p1_eini = '0; p1_eplus = '0; p1_eminus = '0;
    p2_eini = '0; p2_eplus = '0; p2_eminus = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1", "idle in reset", int'(busy) + int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done, "R1", "idle after reset", int'(busy) + int'(done), 0);

    // Full-depth walk fills every address.
    run(DEPTH, 50, 120, 37, 80, 200, 150, 1'b0, "R4");
    // Parity-1 never punctured.
    run(DEPTH / 2, 7, 90, 0, 30, 90, 60, 1'b0, "R5");
    // Short blocks leave the tail untouched.
    run(1, 10, 10, 10, 10, 10, 10, 1'b0, "R4");
    run(5, 1, 3, 3, 1, 3, 3, 1'b0, "R4");
    // Zero-length block writes nothing.
    run(0, 5, 9, 4, 5, 9, 4, 1'b0, "R8");
    // All parameters at their maximum: every parity bit dropped, no wrap.
    run(DEPTH, EMAX, EMAX, EMAX, EMAX, EMAX, EMAX, 1'b0, "R9");
    run(DEPTH - 1, EMAX, EMAX, EMAX - 1, 1, EMAX, 1, 1'b0, "R9");
    // Start during a walk.
    run(300, 40, 100, 55, 60, 100, 30, 1'b1, "R4");

    // Read latency: current mask has position 2 dropped, position 3 kept.
    run(9, 1, 4, 4, 1, 4, 4, 1'b0, "R4");
    read_bit(2, b0);
    check(b0 == 1'b1, "R7", "read of dropped position", int'(b0), 1);
    rd_addr = ADDR_W'(3);
    #1;
    check(rd_bit == 1'b1, "R7", "output before edge", int'(rd_bit), 1);
    @(posedge clk);
    @(negedge clk);
    b1 = rd_bit;
    check(b1 == 1'b0, "R7", "output after edge", int'(b1), 0);

    for (int k = 0; k < 6; k++) rand_run(k == 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule